// File: doc/BRIEF.md
# Unaligned Vector Access Splitter

The block takes a vector load or store whose effective address need not sit on a vector-line boundary. It turns the request into one or two line-aligned requests on a single line port. Every line request carries the aligned line address, the number of bytes it covers, the source data rotated into line lanes, and a byte-enable vector. A per-byte predicate, used as given or inverted, can gate the enables of a store. For a load, the same predicate zeroes bytes of the merged result.

The block accepts one request at a time with a valid/ready handshake. It issues the line requests in address order and waits until the line port accepts each one. For loads, it collects the in-order line responses and rotates them back into vector order. The finished vector is presented for one cycle. A force-align input rounds the address down to the line boundary instead of splitting the access. In that case the block raises a warning flag when low address bits were dropped.

Top module: `vec_access_splitter`

## Requirements
- R1: When the effective offset (address mod VBYTES, taken as zero under force-align) is zero, exactly one line request is issued, at the address rounded down to VBYTES, with byte count VBYTES and the double flag low.
- R2: With a non-zero effective offset, two line requests are issued with the double flag high: first at the rounded-down address, then at that address plus VBYTES.
- R3: For a split access with offset k, the first request carries count VBYTES-k and the second carries count k.
- R4: Store data byte n is placed at line lane (k+n) mod VBYTES. Bytes n < VBYTES-k go to the first line and the rest go to the second.
- R5: Mode encoding on req_mode_i: 2'b00 all bytes, 2'b01 predicate bit set, 2'b10 predicate bit clear, 2'b11 treated as 2'b00. A store enables a lane only if it lies in that request's region and its source byte is selected. A load enables every lane of its region.
- R6: A load result byte n equals the memory byte at (effective base + n). The effective base is the raw address for a split access and the rounded address under force-align.
- R7: A load result byte is zero when the mode deselects it: bit clear in 2'b01, bit set in 2'b10.
- R8: Under force-align, line_misalign_o is high on the request exactly when the dropped low address bits were non-zero. Otherwise it is low.
- R9: req_ready_o is high only when no access is in progress. A line request held while line_ready_i is low keeps its address, count, enables and data unchanged.
- R10: res_valid_o is high for one cycle, in the cycle after the last needed line response is sampled.
- R11: After reset, req_ready_o is high and line_valid_o and res_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Vector request valid |
| req_ready_o | output | 1 | Block idle, request accepted |
| req_addr_i | input | AW | Effective byte address |
| req_store_i | input | 1 | 1 store, 0 load |
| req_align_i | input | 1 | Force-align: round address down, no split |
| req_mode_i | input | 2 | Predicate mode (see R5) |
| req_pred_i | input | VBYTES | Per-byte predicate |
| req_data_i | input | VBYTES*8 | Store data, byte 0 in bits 7:0 |
| line_valid_o | output | 1 | Line request valid |
| line_ready_i | input | 1 | Line port accepts request |
| line_addr_o | output | AW | Aligned line address |
| line_cnt_o | output | log2(VBYTES)+1 | Bytes covered by this request |
| line_be_o | output | VBYTES | Lane byte enables |
| line_data_o | output | VBYTES*8 | Rotated store data |
| line_store_o | output | 1 | Request is a store |
| line_double_o | output | 1 | Access is split in two |
| line_misalign_o | output | 1 | Low address bits dropped under force-align |
| rsp_valid_i | input | 1 | Load line response valid (in order) |
| rsp_data_i | input | VBYTES*8 | Load line data |
| res_valid_o | output | 1 | Merged load result valid |
| res_data_o | output | VBYTES*8 | Merged, predicate-zeroed load vector |

## Verification
The bound checker covers the handshake and framing rules on every cycle:
- a stalled line request stays stable;
- nothing is issued while the block reports ready;
- line addresses are aligned, and a single access covers a full line;
- split counts stay between one and VBYTES-1;
- enable counts never exceed the byte count;
- force-align never splits;
- the result pulse is one cycle wide and follows a response.

The byte-level facts can only be shown by the scoreboard scenarios, which compare against a memory model across aligned, split, masked, inverted and force-align cases, with and without line-port stalls. These facts are lane placement of store data, the exact enable patterns per mode, the merged load bytes, and predicate zero-fill.

// File: rtl/vas_pkg.sv
`timescale 1ns/1ps
package vas_pkg;
  typedef enum logic [1:0] {
    VM_ALL   = 2'b00,
    VM_PRED  = 2'b01,
    VM_NPRED = 2'b10,
    VM_RSVD  = 2'b11
  } vmode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISS0,
    ST_ISS1,
    ST_WAIT,
    ST_DONE
  } vstate_e;
endpackage

// File: rtl/vas_mask_gen.sv
`timescale 1ns/1ps
module vas_mask_gen import vas_pkg::*; #(
  parameter int VBYTES = 16
) (
  input  logic [1:0]        mode_i,
  input  logic [VBYTES-1:0] pred_i,
  output logic [VBYTES-1:0] en_o
);
  vmode_e mode;
  assign mode = vmode_e'(mode_i);

  always_comb begin
    unique case (mode)
      VM_PRED:  en_o = pred_i;
      VM_NPRED: en_o = ~pred_i;
      default:  en_o = '1;
    endcase
  end
endmodule

// File: rtl/vas_lane_map.sv
`timescale 1ns/1ps
module vas_lane_map #(
  parameter int VBYTES = 16,
  localparam int OW = $clog2(VBYTES),
  localparam int DW = VBYTES * 8
) (
  input  logic [OW-1:0]     off_i,
  input  logic [DW-1:0]     data_i,
  input  logic [VBYTES-1:0] mask_i,
  output logic [DW-1:0]     rot_data_o,
  output logic [VBYTES-1:0] rot_mask_o,
  output logic [VBYTES-1:0] hi_region_o
);
  // lane j receives source byte (j - off) mod VBYTES
  for (genvar j = 0; j < VBYTES; j++) begin : g_lane
    logic [OW-1:0] src;
    assign src             = OW'(j) - off_i;
    assign rot_data_o[j*8 +: 8] = data_i[{src, 3'b000} +: 8];
    assign rot_mask_o[j]   = mask_i[src];
    assign hi_region_o[j]  = (OW'(j) >= off_i);
  end
endmodule

// File: rtl/vas_ctrl.sv
`timescale 1ns/1ps
module vas_ctrl import vas_pkg::*; #(
  parameter int VBYTES = 16,
  parameter int AW     = 32,
  localparam int OW    = $clog2(VBYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic          req_store_i,
  input  logic          req_align_i,
  input  logic          line_ready_i,
  input  logic          rsp_valid_i,
  output logic          req_ready_o,
  output logic          line_valid_o,
  output logic          beat_o,
  output logic          store_o,
  output logic          dbl_o,
  output logic          misal_o,
  output logic [AW-1:0] base_o,
  output logic [OW-1:0] off_o,
  output logic          rsp_we0_o,
  output logic          rsp_we1_o,
  output logic          done_o
);
  vstate_e st_q, st_d;
  logic          rcnt_q;
  logic          store_q, dbl_q, misal_q;
  logic [AW-1:0] base_q;
  logic [OW-1:0] off_q;
  logic          accept, rsp_ok, last_rsp;
  logic [OW-1:0] raw_off;

  assign raw_off  = req_addr_i[OW-1:0];
  assign accept   = req_valid_i && (st_q == ST_IDLE);
  assign rsp_ok   = rsp_valid_i && !store_q && (st_q == ST_ISS1 || st_q == ST_WAIT);
  assign last_rsp = rsp_ok && (dbl_q ? rcnt_q : 1'b1);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (req_valid_i) st_d = ST_ISS0;
      ST_ISS0: if (line_ready_i) st_d = dbl_q ? ST_ISS1 : (store_q ? ST_IDLE : ST_WAIT);
      ST_ISS1: if (line_ready_i) st_d = store_q ? ST_IDLE : ST_WAIT;
      ST_WAIT: if (last_rsp) st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      rcnt_q  <= 1'b0;
      store_q <= 1'b0;
      dbl_q   <= 1'b0;
      misal_q <= 1'b0;
      base_q  <= '0;
      off_q   <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        rcnt_q  <= 1'b0;
        store_q <= req_store_i;
        base_q  <= {req_addr_i[AW-1:OW], {OW{1'b0}}};
        off_q   <= req_align_i ? '0 : raw_off;
        dbl_q   <= !req_align_i && (raw_off != '0);
        misal_q <= req_align_i && (raw_off != '0);
      end else if (rsp_ok) begin
        rcnt_q <= 1'b1;
      end
    end
  end

  assign req_ready_o  = (st_q == ST_IDLE);
  assign line_valid_o = (st_q == ST_ISS0) || (st_q == ST_ISS1);
  assign beat_o       = (st_q == ST_ISS1);
  assign store_o      = store_q;
  assign dbl_o        = dbl_q;
  assign misal_o      = misal_q;
  assign base_o       = base_q;
  assign off_o        = off_q;
  assign rsp_we0_o    = rsp_ok && !rcnt_q;
  assign rsp_we1_o    = rsp_ok && rcnt_q;
  assign done_o       = (st_q == ST_DONE);
endmodule

// File: rtl/vas_load_merge.sv
`timescale 1ns/1ps
module vas_load_merge #(
  parameter int VBYTES = 16,
  localparam int OW = $clog2(VBYTES),
  localparam int IW = OW + 1,
  localparam int DW = VBYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we0_i,
  input  logic              we1_i,
  input  logic [DW-1:0]     rsp_data_i,
  input  logic [OW-1:0]     off_i,
  input  logic [VBYTES-1:0] en_i,
  output logic [DW-1:0]     res_data_o
);
  logic [DW-1:0] lo_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (we0_i) lo_q <= rsp_data_i;
      if (we1_i) hi_q <= rsp_data_i;
    end
  end

  // result byte i comes from position i+off of the two-line window {hi,lo}
  for (genvar i = 0; i < VBYTES; i++) begin : g_res
    logic [IW-1:0] idx;
    logic [7:0]    pick;
    assign idx  = IW'(i) + {1'b0, off_i};
    assign pick = idx[OW] ? hi_q[{idx[OW-1:0], 3'b000} +: 8]
                          : lo_q[{idx[OW-1:0], 3'b000} +: 8];
    assign res_data_o[i*8 +: 8] = en_i[i] ? pick : 8'h00;
  end
endmodule

// File: rtl/vec_access_splitter.sv
`timescale 1ns/1ps
module vec_access_splitter #(
  parameter int VBYTES = 16,
  parameter int AW     = 32,
  localparam int OW    = $clog2(VBYTES),
  localparam int CW    = OW + 1,
  localparam int DW    = VBYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [AW-1:0]     req_addr_i,
  input  logic              req_store_i,
  input  logic              req_align_i,
  input  logic [1:0]        req_mode_i,
  input  logic [VBYTES-1:0] req_pred_i,
  input  logic [DW-1:0]     req_data_i,
  output logic              line_valid_o,
  input  logic              line_ready_i,
  output logic [AW-1:0]     line_addr_o,
  output logic [CW-1:0]     line_cnt_o,
  output logic [VBYTES-1:0] line_be_o,
  output logic [DW-1:0]     line_data_o,
  output logic              line_store_o,
  output logic              line_double_o,
  output logic              line_misalign_o,
  input  logic              rsp_valid_i,
  input  logic [DW-1:0]     rsp_data_i,
  output logic              res_valid_o,
  output logic [DW-1:0]     res_data_o
);
  logic              beat, store, dbl, misal, we0, we1, done;
  logic [AW-1:0]     base;
  logic [OW-1:0]     off;
  logic [VBYTES-1:0] en_in, en_q, rot_mask, hi_region, region;
  logic [DW-1:0]     data_q, rot_data;

  vas_mask_gen #(.VBYTES(VBYTES)) u_mask (
    .mode_i (req_mode_i),
    .pred_i (req_pred_i),
    .en_o   (en_in)
  );

  vas_ctrl #(.VBYTES(VBYTES), .AW(AW)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_addr_i   (req_addr_i),
    .req_store_i  (req_store_i),
    .req_align_i  (req_align_i),
    .line_ready_i (line_ready_i),
    .rsp_valid_i  (rsp_valid_i),
    .req_ready_o  (req_ready_o),
    .line_valid_o (line_valid_o),
    .beat_o       (beat),
    .store_o      (store),
    .dbl_o        (dbl),
    .misal_o      (misal),
    .base_o       (base),
    .off_o        (off),
    .rsp_we0_o    (we0),
    .rsp_we1_o    (we1),
    .done_o       (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      en_q   <= '0;
    end else if (req_valid_i && req_ready_o) begin
      data_q <= req_data_i;
      en_q   <= en_in;
    end
  end

  vas_lane_map #(.VBYTES(VBYTES)) u_map (
    .off_i       (off),
    .data_i      (data_q),
    .mask_i      (en_q),
    .rot_data_o  (rot_data),
    .rot_mask_o  (rot_mask),
    .hi_region_o (hi_region)
  );

  // single access: off==0 makes hi_region all ones and count VBYTES
  assign region          = beat ? ~hi_region : hi_region;
  assign line_be_o       = region & (store ? rot_mask : {VBYTES{1'b1}});
  assign line_cnt_o      = beat ? {1'b0, off} : CW'(VBYTES) - {1'b0, off};
  assign line_addr_o     = beat ? base + AW'(VBYTES) : base;
  assign line_data_o     = rot_data;
  assign line_store_o    = store;
  assign line_double_o   = dbl;
  assign line_misalign_o = misal;

  vas_load_merge #(.VBYTES(VBYTES)) u_merge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we0_i      (we0),
    .we1_i      (we1),
    .rsp_data_i (rsp_data_i),
    .off_i      (off),
    .en_i       (en_q),
    .res_data_o (res_data_o)
  );

  assign res_valid_o = done;
endmodule

// File: rtl/vas_checker.sv
`timescale 1ns/1ps
module vas_checker #(
  parameter int VBYTES = 16,
  parameter int AW     = 32,
  localparam int OW    = $clog2(VBYTES),
  localparam int CW    = OW + 1,
  localparam int DW    = VBYTES * 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              line_valid_o,
  input logic              line_ready_i,
  input logic [AW-1:0]     line_addr_o,
  input logic [CW-1:0]     line_cnt_o,
  input logic [VBYTES-1:0] line_be_o,
  input logic [DW-1:0]     line_data_o,
  input logic              line_double_o,
  input logic              line_misalign_o,
  input logic              rsp_valid_i,
  input logic              res_valid_o
);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_o && !line_ready_i |=> line_valid_o && $stable(line_addr_o) &&
      $stable(line_cnt_o) && $stable(line_be_o) && $stable(line_data_o));

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !line_valid_o);

  p_line_aligned_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_o |-> line_addr_o[OW-1:0] == '0);

  p_single_full_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_o && !line_double_o |-> line_cnt_o == CW'(VBYTES));

  p_split_cnt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_o && line_double_o |-> line_cnt_o != '0 && line_cnt_o < CW'(VBYTES));

  p_be_fit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_o |-> $countones(line_be_o) <= int'(line_cnt_o));

  p_mis_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_o && line_misalign_o |-> !line_double_o);

  p_res_after_rsp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $past(rsp_valid_i));

  p_res_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);
endmodule

bind vec_access_splitter vas_checker #(.VBYTES(VBYTES), .AW(AW)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_ready_o     (req_ready_o),
  .line_valid_o    (line_valid_o),
  .line_ready_i    (line_ready_i),
  .line_addr_o     (line_addr_o),
  .line_cnt_o      (line_cnt_o),
  .line_be_o       (line_be_o),
  .line_data_o     (line_data_o),
  .line_double_o   (line_double_o),
  .line_misalign_o (line_misalign_o),
  .rsp_valid_i     (rsp_valid_i),
  .res_valid_o     (res_valid_o)
);

// File: tb/vec_access_splitter_tb.sv
`timescale 1ns/1ps
module vec_access_splitter_tb;
  localparam int V  = 16;
  localparam int AW = 32;
  localparam int DW = V * 8;
  localparam int CW = $clog2(V) + 1;

  logic clk, rst_n;
  logic req_valid, req_ready, req_store, req_align;
  logic [AW-1:0] req_addr;
  logic [1:0] req_mode;
  logic [V-1:0] req_pred;
  logic [DW-1:0] req_data;
  logic line_valid, line_ready, line_store, line_double, line_mis;
  logic [AW-1:0] line_addr;
  logic [CW-1:0] line_cnt;
  logic [V-1:0] line_be;
  logic [DW-1:0] line_data;
  logic rsp_valid;
  logic [DW-1:0] rsp_data;
  logic res_valid;
  logic [DW-1:0] res_data;

  vec_access_splitter #(.VBYTES(V), .AW(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_store_i(req_store), .req_align_i(req_align), .req_mode_i(req_mode),
    .req_pred_i(req_pred), .req_data_i(req_data),
    .line_valid_o(line_valid), .line_ready_i(line_ready), .line_addr_o(line_addr),
    .line_cnt_o(line_cnt), .line_be_o(line_be), .line_data_o(line_data),
    .line_store_o(line_store), .line_double_o(line_double), .line_misalign_o(line_mis),
    .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data),
    .res_valid_o(res_valid), .res_data_o(res_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    logic [AW-1:0] a;
    logic [CW-1:0] c;
    logic [V-1:0]  be;
    logic [DW-1:0] d;
    logic          st, dbl, mis;
  } beat_t;

  beat_t         exp_q[$];
  logic [DW-1:0] res_q[$];
  logic [AW-1:0] rsp_q[$];
  int n_chk = 0, n_bad = 0;
  logic stall = 1'b0;
  logic prev_hold = 1'b0, prev_rsp = 1'b0;
  logic [AW-1:0] prev_a;
  logic [V-1:0] prev_be;

  function automatic logic [7:0] mb(input logic [AW-1:0] a);
    return 8'(a * 13 + (a >> 8) + 7);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [AW-1:0] a, input bit st, input bit al,
                      input logic [1:0] md, input logic [V-1:0] pr, input logic [DW-1:0] dt);
    logic [V-1:0] eff;
    int offr, off, s1;
    logic [AW-1:0] base, ea;
    beat_t b0, b1;
    logic [DW-1:0] r;
    eff  = (md == 2'b01) ? pr : (md == 2'b10) ? ~pr : '1;
    offr = int'(a % V);
    off  = al ? 0 : offr;
    base = a - AW'(offr);
    s1   = V - off;
    b0 = '{a: base, c: CW'(s1), be: '0, d: '0, st: st, dbl: (off != 0), mis: al && (offr != 0)};
    b1 = '{a: base + AW'(V), c: CW'(off), be: '0, d: '0, st: st, dbl: 1'b1, mis: 1'b0};
    for (int k = 0; k < V; k++) begin
      if (k < s1) begin
        b0.d[(off+k)*8 +: 8] = dt[k*8 +: 8];
        b0.be[off+k] = st ? eff[k] : 1'b1;
      end else begin
        b1.d[(k-s1)*8 +: 8] = dt[k*8 +: 8];
        b1.be[k-s1] = st ? eff[k] : 1'b1;
      end
    end
    exp_q.push_back(b0);
    if (off != 0) exp_q.push_back(b1);
    if (!st) begin
      ea = (off == 0) ? base : a;
      for (int i = 0; i < V; i++) r[i*8 +: 8] = eff[i] ? mb(ea + AW'(i)) : 8'h00;
      res_q.push_back(r);
    end
    @(posedge clk); #1;
    while (!req_ready) begin @(posedge clk); #1; end
    req_addr = a; req_store = st; req_align = al; req_mode = md;
    req_pred = pr; req_data = dt; req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_hold)
        check(line_valid && line_addr == prev_a && line_be == prev_be, "R9 stalled request changed",
              DW'({line_valid, line_addr, line_be}), DW'({1'b1, prev_a, prev_be}));
      prev_hold = line_valid && !line_ready;
      prev_a = line_addr;
      prev_be = line_be;
      if (line_valid && line_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R1/R2 unexpected line request", DW'(line_addr), '0);
        end else begin
          beat_t e;
          logic [DW-1:0] bm;
          e = exp_q.pop_front();
          check(line_addr == e.a && line_double == e.dbl && line_store == e.st, "R1/R2 address/double",
                DW'({line_store, line_double, line_addr}), DW'({e.st, e.dbl, e.a}));
          check(line_cnt == e.c, "R3 byte count", DW'(line_cnt), DW'(e.c));
          check(line_be == e.be, "R5 byte enables", DW'(line_be), DW'(e.be));
          check(line_mis == e.mis, "R8 misalign flag", DW'(line_mis), DW'(e.mis));
          if (e.st) begin
            for (int j = 0; j < V; j++) bm[j*8 +: 8] = {8{e.be[j]}};
            check(((line_data ^ e.d) & bm) == '0, "R4 lane data", line_data & bm, e.d & bm);
          end else begin
            rsp_q.push_back(line_addr);
          end
        end
      end
      if (res_valid) begin
        check(prev_rsp, "R10 result timing", DW'(prev_rsp), DW'(1));
        if (res_q.size() == 0) check(1'b0, "R10 extra result", res_data, '0);
        else begin
          logic [DW-1:0] er;
          er = res_q.pop_front();
          check(res_data == er, "R6/R7 load result", res_data, er);
        end
      end
      prev_rsp = rsp_valid;
    end
  end

  // line memory responder, one response per accepted load line
  initial begin
    rsp_valid = 1'b0;
    rsp_data  = '0;
    forever begin
      @(posedge clk); #1;
      if (rsp_q.size() > 0) begin
        logic [AW-1:0] ra;
        ra = rsp_q.pop_front();
        rsp_valid = 1'b1;
        for (int j = 0; j < V; j++) rsp_data[j*8 +: 8] = mb(ra + AW'(j));
      end else begin
        rsp_valid = 1'b0;
      end
    end
  end

  initial begin
    line_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      line_ready = stall ? ~line_ready : 1'b1;
    end
  end

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R10 watchdog expired", '0, '1);
    summary();
    $finish;
  end

  localparam logic [DW-1:0] D0 = 128'h0f0e0d0c0b0a09080706050403020100;
  localparam logic [DW-1:0] D1 = 128'hdeadbeef_cafef00d_12345678_9abcdef0;

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_store = 1'b0;
    req_align = 1'b0; req_mode = 2'b00; req_pred = '0; req_data = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(req_ready && !line_valid && !res_valid, "R11 reset state",
          DW'({req_ready, line_valid, res_valid}), DW'(3'b100));
    #1 rst_n = 1'b1;

    send(32'h100, 1, 0, 2'b00, 16'h0000, D0);  // R1 aligned store
    send(32'h205, 1, 0, 2'b00, 16'h0000, D0);  // R2 R3 R4 split store
    send(32'h30F, 1, 0, 2'b01, 16'hA5C3, D1);  // R5 masked store
    send(32'h401, 1, 0, 2'b10, 16'hA5C3, D1);  // R5 inverted store
    send(32'h50A, 1, 1, 2'b01, 16'h3C0F, D1);  // R8 force-align store
    send(32'h204, 1, 0, 2'b11, 16'h0000, D0);  // R5 reserved mode = all
    send(32'h600, 0, 0, 2'b00, 16'h0000, '0);  // R6 aligned load
    send(32'h719, 0, 0, 2'b00, 16'h0000, '0);  // R6 split load
    send(32'h803, 0, 0, 2'b01, 16'h96F0, '0);  // R7 masked load
    send(32'h90F, 0, 0, 2'b10, 16'h96F0, '0);  // R7 inverted load
    send(32'h7A7, 0, 1, 2'b10, 16'h00FF, '0);  // R8 force-align load
    stall = 1'b1;                               // R9 backpressure
    send(32'hA07, 1, 0, 2'b01, 16'h5A5A, D1);
    send(32'hB02, 0, 0, 2'b00, 16'h0000, '0);
    send(32'hC00, 1, 0, 2'b00, 16'h0000, D0);
    stall = 1'b0;
    send(32'hD0C, 0, 0, 2'b01, 16'hFFFF, '0);

    while (exp_q.size() > 0 || res_q.size() > 0) @(posedge clk);
    repeat (4) @(posedge clk);
    summary();
    $finish;
  end
endmodule